// File: doc/BRIEF.md
# Triggered Time-Stamp Sparsified Pixel Readout

This block is the digital readout of a pixel matrix. Each pixel takes a one-bit hit decision from its discriminator. It latches the hit and keeps a copy of the time stamp that was current at that moment. The time stamp comes from a free-running counter shared by the whole matrix. Each pixel also stores a small threshold trim value, which is written one pixel at a time and presented on a flat bus towards the trim converters.

A trigger carries a stamp from the same time base. Triggers wait in a short queue. The periphery takes them one at a time and broadcasts the stamp to every pixel. Only the pixels whose stored stamp equals the broadcast stamp raise a flag. The periphery then walks through the flagged pixels in a fixed priority order. For each one it emits a word holding the row, the column and the stamp, over a valid/ready interface. Once a word is accepted, that pixel is freed. If a trigger finds no matching pixel, the periphery emits one end-of-event word instead, so that an empty event still shows up in the output stream.

Top module: `trs_readout`

## Requirements
- R1: While reset is asserted, `out_valid_o` is 0, `trig_ovf_o` is 0, `ts_o` is 0 and every trim field is 0.
- R2: `ts_o` increases by one on every clock edge. After its maximum value it wraps to 0.
- R3: A pixel with hit_i high in a cycle stores the `ts_o` value of that same cycle. While that hit is still unread, any further hit on the same pixel is ignored and leaves the stored stamp unchanged.
- R4: A trigger with stamp T reads out only the pixels whose stored stamp equals T. Hit pixels with any other stamp keep their hits for a later trigger.
- R5: Output word layout, from the MSB down: marker (1 bit), row, column, stamp. For a pixel word the marker is 0. The pixel index is row*COLS+column.
- R6: Within one event, pixel words come out in this order: lowest row first, and within a row, lowest column first.
- R7: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_word_o` does not change.
- R8: After its word is accepted, a pixel is cleared. A later trigger with the same stamp no longer finds it.
- R9: An event that matches no pixel emits exactly one word: marker 1, row 0, column 0, stamp T.
- R10: Up to TQ_DEPTH triggers that arrive during a scan are queued. They are served in arrival order.
- R11: A trigger that arrives while the queue holds TQ_DEPTH entries is dropped. It sets `trig_ovf_o`, which stays set until reset.
- R12: A trim write changes only the addressed pixel's field, `trim_o[idx*TRIM_W +: TRIM_W]`. All other fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | ROWS*COLS | Discriminator hit bit per pixel; bit index is row*COLS+column |
| trig_i | input | 1 | Trigger strobe |
| trig_ts_i | input | TS_W | Stamp carried by the trigger |
| trim_we_i | input | 1 | Trim write enable |
| trim_idx_i | input | clog2(ROWS*COLS) | Pixel index of the trim write |
| trim_d_i | input | TRIM_W | Trim value to write |
| trim_o | output | ROWS*COLS*TRIM_W | Trim value of every pixel |
| ts_o | output | TS_W | Current time stamp |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Output word accepted |
| out_word_o | output | 1+clog2(ROWS)+clog2(COLS)+TS_W | {marker, row, column, stamp} |
| trig_ovf_o | output | 1 | Sticky flag: a trigger was dropped because the queue was full |

## Verification
The bench builds the block as a 3 by 4 matrix with a 4-bit stamp and a trigger queue of 4 entries. A 4-bit stamp wraps every 16 cycles, so the wrap is checked directly. It also means stamps that are a few cycles apart separate pixels within a short test. The small matrix lets one event cover several rows and columns, which tests the scan order. With the output held back, the queue fills after a handful of triggers, so both the overflow and the in-order replay of queued empty events can be reached.

// File: rtl/trs_pkg.sv
package trs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMP  = 2'd1,
    ST_SCAN = 2'd2,
    ST_EOE  = 2'd3
  } scan_st_e;
endpackage

// File: rtl/trs_pixel.sv
module trs_pixel #(
  parameter int TS_W   = 8,
  parameter int TRIM_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [TS_W-1:0]   ts_i,
  input  logic              cmp_en_i,
  input  logic [TS_W-1:0]   cmp_ts_i,
  input  logic              clr_i,
  input  logic              trim_we_i,
  input  logic [TRIM_W-1:0] trim_d_i,
  output logic              flag_o,
  output logic [TRIM_W-1:0] trim_o
);
  logic            hit_q, flag_q;
  logic [TS_W-1:0] ts_q;
  logic [TRIM_W-1:0] trim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      flag_q <= 1'b0;
      ts_q   <= '0;
    end else if (clr_i) begin
      hit_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      // an unread hit blocks new captures
      if (hit_i && !hit_q) begin
        hit_q <= 1'b1;
        ts_q  <= ts_i;
      end
      if (cmp_en_i) flag_q <= hit_q && (ts_q == cmp_ts_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        trim_q <= '0;
    else if (trim_we_i) trim_q <= trim_d_i;
  end

  assign flag_o = flag_q;
  assign trim_o = trim_q;

  p_flag_needs_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |-> hit_q);
  p_hold_unread_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_q && !clr_i) |=> (hit_q && $stable(ts_q)));
endmodule

// File: rtl/trs_trig_fifo.sv
module trs_trig_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  p_pop_nonempty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_push_room_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> !full_o);
  p_cnt_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/trs_prio_enc.sv
module trs_prio_enc #(
  parameter int N = 16
) (
  input  logic [N-1:0]         req_i,
  output logic [$clog2(N)-1:0] idx_o,
  output logic                 any_o
);
  localparam int IW = $clog2(N);

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |req_i;

  always_comb begin
    if (any_o) begin
      a_idx_set_r6: assert (req_i[idx_o]);
    end
  end
endmodule

// File: rtl/trs_readout.sv
module trs_readout
  import trs_pkg::*;
#(
  parameter int ROWS     = 16,
  parameter int COLS     = 16,
  parameter int TS_W     = 8,
  parameter int TRIM_W   = 4,
  parameter int TQ_DEPTH = 4,
  localparam int N       = ROWS * COLS,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int COL_W   = $clog2(COLS),
  localparam int IDX_W   = $clog2(N),
  localparam int WORD_W  = 1 + ROW_W + COL_W + TS_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N-1:0]          hit_i,
  input  logic                  trig_i,
  input  logic [TS_W-1:0]       trig_ts_i,
  input  logic                  trim_we_i,
  input  logic [IDX_W-1:0]      trim_idx_i,
  input  logic [TRIM_W-1:0]     trim_d_i,
  output logic [N*TRIM_W-1:0]   trim_o,
  output logic [TS_W-1:0]       ts_o,
  output logic                  out_valid_o,
  input  logic                  out_ready_i,
  output logic [WORD_W-1:0]     out_word_o,
  output logic                  trig_ovf_o
);
  logic [TS_W-1:0]  ts_q, cur_ts_q, fifo_ts;
  logic             fifo_empty, fifo_full, fifo_push, fifo_pop;
  logic             ovf_q, found_q, cmp_en, scan_acc, any_flag;
  logic [N-1:0]     flags, clr;
  logic [IDX_W-1:0] sel_idx, row_full, col_full;
  scan_st_e         st_q, st_d;

  // time base
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_q <= '0;
    else         ts_q <= ts_q + 1'b1;
  end
  assign ts_o = ts_q;

  // trigger queue
  assign fifo_push = trig_i && !fifo_full;
  assign fifo_pop  = (st_q == ST_IDLE) && !fifo_empty;

  trs_trig_fifo #(.W(TS_W), .DEPTH(TQ_DEPTH)) u_tq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (fifo_push),
    .data_i  (trig_ts_i),
    .pop_i   (fifo_pop),
    .data_o  (fifo_ts),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   ovf_q <= 1'b0;
    else if (trig_i && fifo_full)  ovf_q <= 1'b1;
  end
  assign trig_ovf_o = ovf_q;

  // pixel matrix
  assign cmp_en = (st_q == ST_CMP);

  for (genvar gi = 0; gi < N; gi++) begin : g_px
    trs_pixel #(.TS_W(TS_W), .TRIM_W(TRIM_W)) u_px (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hit_i     (hit_i[gi]),
      .ts_i      (ts_q),
      .cmp_en_i  (cmp_en),
      .cmp_ts_i  (cur_ts_q),
      .clr_i     (clr[gi]),
      .trim_we_i (trim_we_i && (trim_idx_i == IDX_W'(gi))),
      .trim_d_i  (trim_d_i),
      .flag_o    (flags[gi]),
      .trim_o    (trim_o[gi*TRIM_W +: TRIM_W])
    );
    assign clr[gi] = scan_acc && (sel_idx == IDX_W'(gi));
  end

  // scan
  trs_prio_enc #(.N(N)) u_pe (
    .req_i (flags),
    .idx_o (sel_idx),
    .any_o (any_flag)
  );

  assign scan_acc = (st_q == ST_SCAN) && any_flag && out_ready_i;
  assign row_full = sel_idx / IDX_W'(COLS);
  assign col_full = sel_idx % IDX_W'(COLS);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (!fifo_empty) st_d = ST_CMP;
      ST_CMP:  st_d = ST_SCAN;
      ST_SCAN: if (!any_flag) st_d = found_q ? ST_IDLE : ST_EOE;
      ST_EOE:  if (out_ready_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cur_ts_q <= '0;
      found_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (fifo_pop)      cur_ts_q <= fifo_ts;
      if (cmp_en)        found_q  <= 1'b0;
      else if (scan_acc) found_q  <= 1'b1;
    end
  end

  always_comb begin
    out_valid_o = 1'b0;
    out_word_o  = {1'b1, {(ROW_W + COL_W){1'b0}}, cur_ts_q};
    if (st_q == ST_EOE) begin
      out_valid_o = 1'b1;
    end else if (st_q == ST_SCAN && any_flag) begin
      out_valid_o = 1'b1;
      out_word_o  = {1'b0, row_full[ROW_W-1:0], col_full[COL_W-1:0], cur_ts_q};
    end
  end

  p_valid_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_word_o)));
  p_ovf_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_ovf_o |=> trig_ovf_o);
  p_one_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr));
  p_ts_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_q == {TS_W{1'b1}}) |=> (ts_q == '0));
  p_eoe_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EOE) |-> !found_q);
endmodule

// File: tb/trs_readout_tb_top.sv
module trs_readout_tb_top;
  localparam int ROWS = 3, COLS = 4, TS_W = 4, TRIM_W = 4, TQ = 4;
  localparam int N = ROWS * COLS;
  localparam int IDX_W = $clog2(N);
  localparam int WORD_W = 1 + 2 + 2 + TS_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] hit = '0;
  logic trig = 1'b0, we = 1'b0, ready = 1'b0;
  logic [TS_W-1:0] trig_ts = '0;
  logic [IDX_W-1:0] tidx = '0;
  logic [TRIM_W-1:0] td = '0;
  logic [N*TRIM_W-1:0] trim;
  logic [TS_W-1:0] ts;
  logic valid, ovf;
  logic [WORD_W-1:0] word;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4ns clk = ~clk;

  trs_readout #(.ROWS(ROWS), .COLS(COLS), .TS_W(TS_W), .TRIM_W(TRIM_W), .TQ_DEPTH(TQ)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hit_i(hit), .trig_i(trig), .trig_ts_i(trig_ts),
    .trim_we_i(we), .trim_idx_i(tidx), .trim_d_i(td), .trim_o(trim), .ts_o(ts),
    .out_valid_o(valid), .out_ready_i(ready), .out_word_o(word), .trig_ovf_o(ovf)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] pw(input int r, input int c, input logic [TS_W-1:0] t);
    return {1'b0, 2'(r), 2'(c), t};
  endfunction

  function automatic logic [WORD_W-1:0] ew(input logic [TS_W-1:0] t);
    return {1'b1, 4'b0000, t};
  endfunction

  task automatic pulse_hit(input logic [N-1:0] m, output logic [TS_W-1:0] st);
    @(negedge clk); hit = m; st = ts;
    @(negedge clk); hit = '0;
  endtask

  task automatic fire_trig(input logic [TS_W-1:0] t);
    @(negedge clk); trig = 1'b1; trig_ts = t;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic take_word(input string tag, input logic [WORD_W-1:0] exp);
    bit got = 1'b0;
    logic [WORD_W-1:0] w = '0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); ready = 1'b1;
      if (valid) begin got = 1'b1; w = word; break; end
    end
    chk(got && (w == exp), tag, {55'd0, w}, {55'd0, exp});
  endtask

  task automatic expect_idle(input string tag, input int n);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (valid) seen = 1'b1;
    end
    chk(!seen, tag, 64'(seen), 64'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!valid && !ovf && ts == '0 && trim == '0, "R1 reset state",
        {valid, ovf, ts}, 64'd0);
  endtask

  task automatic t_ts();
    logic [TS_W-1:0] prev;
    bit step_ok = 1'b1, wrapped = 1'b0;
    @(negedge clk); prev = ts;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ts != prev + 1'b1) step_ok = 1'b0;
      if (prev == 4'hF && ts == 4'h0) wrapped = 1'b1;
      prev = ts;
    end
    chk(step_ok, "R2 stamp steps by one", 64'(ts), 64'(prev));
    chk(wrapped, "R2 stamp wraps to zero", 64'(wrapped), 64'd1);
  endtask

  task automatic t_trim();
    logic [N*TRIM_W-1:0] exp = '0;
    @(negedge clk); we = 1'b1; tidx = 7; td = 4'hA;
    @(negedge clk); tidx = 0; td = 4'h3;
    @(negedge clk); we = 1'b0;
    exp[7*TRIM_W +: TRIM_W] = 4'hA;
    exp[0 +: TRIM_W] = 4'h3;
    @(negedge clk);
    chk(trim == exp, "R12 per-pixel trim write", 64'(trim), 64'(exp));
  endtask

  task automatic t_single();
    logic [TS_W-1:0] s;
    pulse_hit(12'(1) << 6, s);
    fire_trig(s);
    take_word("R3 R5 single hit word", pw(1, 2, s));
    expect_idle("R9 no end word after match", 8);
  endtask

  task automatic t_order();
    logic [TS_W-1:0] s;
    pulse_hit((12'(1) << 9) | (12'(1) << 2) | (12'(1) << 4), s);
    fire_trig(s);
    take_word("R6 order first", pw(0, 2, s));
    take_word("R6 order second", pw(1, 0, s));
    take_word("R6 order third", pw(2, 1, s));
    expect_idle("R6 no extra word", 6);
  endtask

  task automatic t_select();
    logic [TS_W-1:0] a, b;
    pulse_hit(12'(1) << 3, a);
    repeat (3) @(negedge clk);
    pulse_hit(12'(1) << 8, b);
    fire_trig(b);
    take_word("R4 matching pixel only", pw(2, 0, b));
    expect_idle("R4 other pixel silent", 6);
    fire_trig(a);
    take_word("R4 kept hit read later", pw(0, 3, a));
  endtask

  task automatic t_ignore();
    logic [TS_W-1:0] a, b;
    pulse_hit(12'(1) << 1, a);
    repeat (2) @(negedge clk);
    pulse_hit(12'(1) << 1, b);
    fire_trig(b);
    take_word("R3 R9 second hit ignored, end word", ew(b));
    expect_idle("R9 single end word", 6);
    fire_trig(a);
    take_word("R3 first stamp kept", pw(0, 1, a));
    fire_trig(a);
    take_word("R8 accepted pixel cleared", ew(a));
  endtask

  task automatic t_hold();
    logic [TS_W-1:0] s;
    logic [WORD_W-1:0] w0;
    bit ok = 1'b1;
    @(negedge clk); ready = 1'b0;
    pulse_hit(12'(1) << 10, s);
    fire_trig(s);
    for (int i = 0; i < 20 && !valid; i++) @(negedge clk);
    w0 = word;
    repeat (4) begin
      @(negedge clk);
      if (!valid || word != w0) ok = 1'b0;
    end
    chk(ok && w0 == pw(2, 2, s), "R7 word held while stalled", 64'(word), 64'(pw(2, 2, s)));
    take_word("R7 word after release", pw(2, 2, s));
  endtask

  task automatic t_queue();
    logic [TS_W-1:0] s;
    @(negedge clk); ready = 1'b0;
    pulse_hit(12'(1) << 5, s);
    fire_trig(s);
    for (int i = 0; i < 20 && !valid; i++) @(negedge clk);
    for (int k = 1; k <= 4; k++) fire_trig(s + 4'(k));
    chk(!ovf, "R11 no overflow at four queued", 64'(ovf), 64'd0);
    fire_trig(s + 4'd5);
    chk(ovf, "R11 overflow on fifth", 64'(ovf), 64'd1);
    take_word("R10 stalled event word", pw(1, 1, s));
    for (int k = 1; k <= 4; k++) take_word("R10 queued event in order", ew(s + 4'(k)));
    expect_idle("R11 dropped trigger gives nothing", 10);
    chk(ovf, "R11 overflow sticky", 64'(ovf), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_ts();
    t_trim();
    @(negedge clk); ready = 1'b1;
    t_single();
    t_order();
    t_select();
    t_ignore();
    t_hold();
    t_queue();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule